// File: doc/BRIEF.md
# Dual-Port Control Decoder with Mailboxes

This block is the port-side control for a bidirectional buffer made of two FIFOs, with each port on its own clock. Each port has four control inputs: an active-low select, a direction bit, an enable and a mailbox bit. The block decodes them into one of five actions. These are a FIFO write, a FIFO read, a mail write, a mail read, or nothing. It produces the write and read strobes for the external FIFO arrays and the output-enable for the port's data bus.

The block also holds two mailbox registers for messages that bypass the FIFOs. Port A posts to mailbox 1 and port B takes from it. Port B posts to mailbox 2 and port A takes from it. Each mailbox has a flag that reads HIGH when empty. Posting clears the flag in the writer's domain at once. The flag change reaches the reader through a toggle handshake and a two-flop synchronizer. Taking sets the flag in the reader's domain, and that change travels back the same way. While a mailbox is full, further posts to it are dropped.

Top module: `bififo_port_ctl`

## Requirements
- R1: While a port's select input is HIGH, that port's output-enable is LOW and it issues no FIFO strobe and no mailbox action.
- R2: While select is LOW, the port's output-enable equals the inverse of its direction bit (direction HIGH = input, LOW = drive).
- R3: With enable LOW, a port issues no FIFO strobe, and a clock edge neither posts nor takes mail.
- R4: Port A, select LOW, enable HIGH, mailbox bit LOW: direction HIGH raises the FIFO1 write strobe, direction LOW raises the FIFO2 read strobe.
- R5: Port B, select LOW, enable HIGH, mailbox bit LOW: direction HIGH raises the FIFO2 write strobe, direction LOW raises the FIFO1 read strobe.
- R6: Posting stores the port's input data. Port A posts to mailbox 1 and port B posts to mailbox 2, each with select LOW, enable, mailbox bit and direction HIGH on the port's rising clock edge. After that edge the writer-side empty flag is LOW, and the reader-side flag goes LOW within three reader clock edges.
- R7: A post to a mailbox whose writer-side flag is LOW leaves the stored word unchanged.
- R8: Taking sets the reader-side empty flag HIGH after the edge. Port B takes from mailbox 1 and port A takes from mailbox 2, with select LOW, enable HIGH, mailbox bit HIGH and direction LOW. The writer-side flag returns HIGH within three writer clock edges.
- R9: When a port's select is LOW, direction is LOW and the mailbox bit is HIGH, its data output shows the mailbox it takes from. Otherwise it shows that port's FIFO read-data input.
- R10: With the mailbox bit HIGH, a port raises no FIFO strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| a_cs_ni | input | 1 | Port A select, active low |
| a_wr_i | input | 1 | Port A direction (1 write, 0 read) |
| a_en_i | input | 1 | Port A enable |
| a_mb_i | input | 1 | Port A mailbox bit |
| a_data_i | input | 36 | Port A inbound data |
| a_fifo_rdata_i | input | 36 | FIFO2 output register |
| a_data_o | output | 36 | Port A outbound data |
| a_oe_o | output | 1 | Port A bus drive enable |
| a_fifo_wr_o | output | 1 | FIFO1 write strobe |
| a_fifo_rd_o | output | 1 | FIFO2 read strobe |
| b_cs_ni | input | 1 | Port B select, active low |
| b_wr_i | input | 1 | Port B direction |
| b_en_i | input | 1 | Port B enable |
| b_mb_i | input | 1 | Port B mailbox bit |
| b_data_i | input | 36 | Port B inbound data |
| b_fifo_rdata_i | input | 36 | FIFO1 output register |
| b_data_o | output | 36 | Port B outbound data |
| b_oe_o | output | 1 | Port B bus drive enable |
| b_fifo_wr_o | output | 1 | FIFO2 write strobe |
| b_fifo_rd_o | output | 1 | FIFO1 read strobe |
| mb1_empty_a_o | output | 1 | Mailbox 1 empty, port A domain |
| mb1_empty_b_o | output | 1 | Mailbox 1 empty, port B domain |
| mb2_empty_a_o | output | 1 | Mailbox 2 empty, port A domain |
| mb2_empty_b_o | output | 1 | Mailbox 2 empty, port B domain |

## Verification
The assertions assume that each port's control inputs are stable around its own rising clock edge. They also assume that a port changes only its own inputs, so the two domains interact only through the toggle synchronizers. The bench sweeps every control combination on both ports while the clocks are held still, so the decode checks meet no clock edge. Every mailbox transfer is driven one cycle after the relevant edge. The bench waits at least four clock edges of the other domain before it judges a flag that has crossed.

// File: rtl/bififo_ctl_pkg.sv
package bififo_ctl_pkg;
  localparam int unsigned DATA_W = 36;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_FIFO_WR = 3'd1,
    OP_FIFO_RD = 3'd2,
    OP_MAIL_WR = 3'd3,
    OP_MAIL_RD = 3'd4
  } port_op_e;
endpackage

// File: rtl/sync_ff.sv
module sync_ff #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/port_decode.sv
module port_decode
  import bififo_ctl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cs_ni,
  input  logic     wr_i,
  input  logic     en_i,
  input  logic     mb_i,
  output port_op_e op_o,
  output logic     fifo_wr_o,
  output logic     fifo_rd_o,
  output logic     mail_wr_o,
  output logic     mail_rd_o,
  output logic     mail_sel_o,
  output logic     oe_o
);
  port_op_e op;

  always_comb begin
    op = OP_NONE;
    if (!cs_ni && en_i) begin
      unique case ({mb_i, wr_i})
        2'b01:   op = OP_FIFO_WR;
        2'b00:   op = OP_FIFO_RD;
        2'b11:   op = OP_MAIL_WR;
        default: op = OP_MAIL_RD;
      endcase
    end
  end

  assign op_o       = op;
  assign fifo_wr_o  = (op == OP_FIFO_WR);
  assign fifo_rd_o  = (op == OP_FIFO_RD);
  assign mail_wr_o  = (op == OP_MAIL_WR);
  assign mail_rd_o  = (op == OP_MAIL_RD);
  // output mux follows bus state, not enable
  assign mail_sel_o = !cs_ni && !wr_i && mb_i;
  assign oe_o       = !cs_ni && !wr_i;

  p_cs_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (!oe_o && !fifo_wr_o && !fifo_rd_o && !mail_wr_o && !mail_rd_o));
  p_en_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!fifo_wr_o && !fifo_rd_o && !mail_wr_o && !mail_rd_o));
  p_mail_no_fifo_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_i |-> (!fifo_wr_o && !fifo_rd_o));
  p_strobe_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fifo_wr_o, fifo_rd_o, mail_wr_o, mail_rd_o}));
endmodule

// File: rtl/mail_channel.sv
module mail_channel #(
  parameter int unsigned W      = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic         wclk_i,
  input  logic         rclk_i,
  input  logic         rst_ni,
  input  logic         wr_req_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_req_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_w_o,
  output logic         empty_r_o
);
  logic         wtgl_q, rtgl_q;
  logic         wtgl_s, rtgl_s;
  logic [W-1:0] mbox_q;
  logic         wr_ok, rd_ok;

  // reader toggle seen in writer domain, writer toggle seen in reader domain
  sync_ff #(.STAGES(STAGES)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rtgl_q), .q_o(rtgl_s));
  sync_ff #(.STAGES(STAGES)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wtgl_q), .q_o(wtgl_s));

  assign empty_w_o = (wtgl_q == rtgl_s);
  assign empty_r_o = (wtgl_s == rtgl_q);
  assign wr_ok     = wr_req_i && empty_w_o;
  assign rd_ok     = rd_req_i && !empty_r_o;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wtgl_q <= 1'b0;
      mbox_q <= '0;
    end else if (wr_ok) begin
      wtgl_q <= ~wtgl_q;
      mbox_q <= wdata_i;
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)    rtgl_q <= 1'b0;
    else if (rd_ok) rtgl_q <= ~rtgl_q;
  end

  assign rdata_o = mbox_q;

  p_post_fills_r6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_req_i && empty_w_o) |=> !empty_w_o);
  p_full_drop_r7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_req_i && !empty_w_o) |=> $stable(mbox_q));
  p_take_empties_r8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_req_i && !empty_r_o) |=> empty_r_o);
  p_reader_data_stable_r7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!empty_r_o && !$past(empty_r_o)) |-> $stable(mbox_q));
endmodule

// File: rtl/bififo_port_ctl.sv
module bififo_port_ctl
  import bififo_ctl_pkg::*;
#(
  parameter int unsigned W      = DATA_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic         clk_a_i,
  input  logic         clk_b_i,
  input  logic         rst_ni,
  input  logic         a_cs_ni,
  input  logic         a_wr_i,
  input  logic         a_en_i,
  input  logic         a_mb_i,
  input  logic [W-1:0] a_data_i,
  input  logic [W-1:0] a_fifo_rdata_i,
  output logic [W-1:0] a_data_o,
  output logic         a_oe_o,
  output logic         a_fifo_wr_o,
  output logic         a_fifo_rd_o,
  input  logic         b_cs_ni,
  input  logic         b_wr_i,
  input  logic         b_en_i,
  input  logic         b_mb_i,
  input  logic [W-1:0] b_data_i,
  input  logic [W-1:0] b_fifo_rdata_i,
  output logic [W-1:0] b_data_o,
  output logic         b_oe_o,
  output logic         b_fifo_wr_o,
  output logic         b_fifo_rd_o,
  output logic         mb1_empty_a_o,
  output logic         mb1_empty_b_o,
  output logic         mb2_empty_a_o,
  output logic         mb2_empty_b_o
);
  port_op_e     a_op, b_op;
  logic         a_mail_wr, a_mail_rd, a_mail_sel;
  logic         b_mail_wr, b_mail_rd, b_mail_sel;
  logic [W-1:0] mb1_q, mb2_q;

  port_decode u_dec_a (
    .clk_i(clk_a_i), .rst_ni(rst_ni),
    .cs_ni(a_cs_ni), .wr_i(a_wr_i), .en_i(a_en_i), .mb_i(a_mb_i),
    .op_o(a_op), .fifo_wr_o(a_fifo_wr_o), .fifo_rd_o(a_fifo_rd_o),
    .mail_wr_o(a_mail_wr), .mail_rd_o(a_mail_rd),
    .mail_sel_o(a_mail_sel), .oe_o(a_oe_o));

  port_decode u_dec_b (
    .clk_i(clk_b_i), .rst_ni(rst_ni),
    .cs_ni(b_cs_ni), .wr_i(b_wr_i), .en_i(b_en_i), .mb_i(b_mb_i),
    .op_o(b_op), .fifo_wr_o(b_fifo_wr_o), .fifo_rd_o(b_fifo_rd_o),
    .mail_wr_o(b_mail_wr), .mail_rd_o(b_mail_rd),
    .mail_sel_o(b_mail_sel), .oe_o(b_oe_o));

  // mailbox 1: A posts, B takes
  mail_channel #(.W(W), .STAGES(STAGES)) u_mb1 (
    .wclk_i(clk_a_i), .rclk_i(clk_b_i), .rst_ni(rst_ni),
    .wr_req_i(a_mail_wr), .wdata_i(a_data_i), .rd_req_i(b_mail_rd),
    .rdata_o(mb1_q), .empty_w_o(mb1_empty_a_o), .empty_r_o(mb1_empty_b_o));

  // mailbox 2: B posts, A takes
  mail_channel #(.W(W), .STAGES(STAGES)) u_mb2 (
    .wclk_i(clk_b_i), .rclk_i(clk_a_i), .rst_ni(rst_ni),
    .wr_req_i(b_mail_wr), .wdata_i(b_data_i), .rd_req_i(a_mail_rd),
    .rdata_o(mb2_q), .empty_w_o(mb2_empty_b_o), .empty_r_o(mb2_empty_a_o));

  assign a_data_o = a_mail_sel ? mb2_q : a_fifo_rdata_i;
  assign b_data_o = b_mail_sel ? mb1_q : b_fifo_rdata_i;

  p_a_mux_r9: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!a_cs_ni && !a_wr_i && a_mb_i) |-> (a_data_o == mb2_q));
  p_b_mux_r9: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (a_op == OP_NONE || b_op != OP_NONE || b_mb_i || b_cs_ni || b_wr_i)
      |-> (b_data_o == b_fifo_rdata_i || b_mail_sel));
  p_a_oe_r2: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !a_cs_ni |-> (a_oe_o == !a_wr_i));
  p_b_oe_r2: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !b_cs_ni |-> (b_oe_o == !b_wr_i));
endmodule

// File: tb/bififo_port_ctl_tb.sv
module bififo_port_ctl_tb;
  localparam int W = 36;

  logic clk_a = 0, clk_b = 0, run = 0, rst_ni = 0;
  logic a_cs_ni = 1, a_wr_i = 0, a_en_i = 0, a_mb_i = 0;
  logic b_cs_ni = 1, b_wr_i = 0, b_en_i = 0, b_mb_i = 0;
  logic [W-1:0] a_data_i = '0, b_data_i = '0;
  logic [W-1:0] a_fifo_rdata_i = 36'h0A5A5A5A5, b_fifo_rdata_i = 36'h5C3C3C3C3;
  logic [W-1:0] a_data_o, b_data_o;
  logic a_oe_o, a_fifo_wr_o, a_fifo_rd_o, b_oe_o, b_fifo_wr_o, b_fifo_rd_o;
  logic mb1_empty_a_o, mb1_empty_b_o, mb2_empty_a_o, mb2_empty_b_o;
  int checks = 0, errors = 0;
  bit done = 0;

  initial forever begin #10; if (run) clk_a = ~clk_a; end
  initial forever begin #13; if (run) clk_b = ~clk_b; end

  bififo_port_ctl u_dut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_ni),
    .a_cs_ni(a_cs_ni), .a_wr_i(a_wr_i), .a_en_i(a_en_i), .a_mb_i(a_mb_i),
    .a_data_i(a_data_i), .a_fifo_rdata_i(a_fifo_rdata_i), .a_data_o(a_data_o),
    .a_oe_o(a_oe_o), .a_fifo_wr_o(a_fifo_wr_o), .a_fifo_rd_o(a_fifo_rd_o),
    .b_cs_ni(b_cs_ni), .b_wr_i(b_wr_i), .b_en_i(b_en_i), .b_mb_i(b_mb_i),
    .b_data_i(b_data_i), .b_fifo_rdata_i(b_fifo_rdata_i), .b_data_o(b_data_o),
    .b_oe_o(b_oe_o), .b_fifo_wr_o(b_fifo_wr_o), .b_fifo_rd_o(b_fifo_rd_o),
    .mb1_empty_a_o(mb1_empty_a_o), .mb1_empty_b_o(mb1_empty_b_o),
    .mb2_empty_a_o(mb2_empty_a_o), .mb2_empty_b_o(mb2_empty_b_o));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic post_a(input logic [W-1:0] d);
    a_cs_ni = 0; a_wr_i = 1; a_mb_i = 1; a_en_i = 1; a_data_i = d;
    @(posedge clk_a); #1;
    a_en_i = 0; a_cs_ni = 1;
  endtask

  task automatic post_b(input logic [W-1:0] d);
    b_cs_ni = 0; b_wr_i = 1; b_mb_i = 1; b_en_i = 1; b_data_i = d;
    @(posedge clk_b); #1;
    b_en_i = 0; b_cs_ni = 1;
  endtask

  task automatic take_b(input logic [W-1:0] exp);
    b_cs_ni = 0; b_wr_i = 0; b_mb_i = 1; b_en_i = 1; #1;
    chk("R9 b mailbox view", b_data_o, exp);
    @(posedge clk_b); #1;
    b_en_i = 0; b_cs_ni = 1;
  endtask

  task automatic take_a(input logic [W-1:0] exp);
    a_cs_ni = 0; a_wr_i = 0; a_mb_i = 1; a_en_i = 1; #1;
    chk("R9 a mailbox view", a_data_o, exp);
    @(posedge clk_a); #1;
    a_en_i = 0; a_cs_ni = 1;
  endtask

  task automatic wait_a(input int n);
    repeat (n) @(posedge clk_a); #1;
  endtask
  task automatic wait_b(input int n);
    repeat (n) @(posedge clk_b); #1;
  endtask

  initial begin
    #5;
    chk("R1 reset a_oe", a_oe_o, 0);
    chk("R6 reset mb1 empty", {mb1_empty_a_o, mb1_empty_b_o}, 2'b11);
    chk("R6 reset mb2 empty", {mb2_empty_a_o, mb2_empty_b_o}, 2'b11);
    rst_ni = 1; #5;
    // decode sweep with clocks halted
    for (int i = 0; i < 16; i++) begin
      logic cs, wr, en, mb;
      {cs, wr, en, mb} = i[3:0];
      a_cs_ni = cs; a_wr_i = wr; a_en_i = en; a_mb_i = mb;
      b_cs_ni = cs; b_wr_i = wr; b_en_i = en; b_mb_i = mb;
      #1;
      chk(cs ? "R1 a_oe" : "R2 a_oe", a_oe_o, !cs && !wr);
      chk(cs ? "R1 b_oe" : "R2 b_oe", b_oe_o, !cs && !wr);
      chk(en ? "R4 a strobes" : "R3 a strobes", {a_fifo_wr_o, a_fifo_rd_o},
          {!cs && en && wr && !mb, !cs && en && !wr && !mb});
      chk(en ? "R5 b strobes" : "R3 b strobes", {b_fifo_wr_o, b_fifo_rd_o},
          {!cs && en && wr && !mb, !cs && en && !wr && !mb});
      if (mb) chk("R10 no fifo strobe", {a_fifo_wr_o, a_fifo_rd_o, b_fifo_wr_o, b_fifo_rd_o}, 0);
      chk("R9 a mux", a_data_o, (!cs && !wr && mb) ? '0 : a_fifo_rdata_i);
      chk("R9 b mux", b_data_o, (!cs && !wr && mb) ? '0 : b_fifo_rdata_i);
    end
    a_cs_ni = 1; b_cs_ni = 1; a_en_i = 0; b_en_i = 0; a_mb_i = 0; b_mb_i = 0;
    run = 1;
    wait_a(2);
    // enable low: no post
    a_cs_ni = 0; a_wr_i = 1; a_mb_i = 1; a_en_i = 0; a_data_i = 36'h111111111;
    wait_a(2);
    chk("R3 en low no post", mb1_empty_a_o, 1);
    a_cs_ni = 1;
    // mailbox 1 path
    post_a(36'h9ABCDEF01);
    chk("R6 mb1 writer flag", mb1_empty_a_o, 0);
    wait_b(4);
    chk("R6 mb1 reader flag", mb1_empty_b_o, 0);
    post_a(36'h222222222);
    chk("R7 mb1 still full", mb1_empty_a_o, 0);
    take_b(36'h9ABCDEF01);
    chk("R8 mb1 reader empty", mb1_empty_b_o, 1);
    wait_a(4);
    chk("R8 mb1 writer empty", mb1_empty_a_o, 1);
    post_a(36'h333333333);
    wait_b(4);
    take_b(36'h333333333);
    // mailbox 2 path
    post_b(36'hF0F0F0F0F);
    chk("R6 mb2 writer flag", mb2_empty_b_o, 0);
    wait_a(4);
    chk("R6 mb2 reader flag", mb2_empty_a_o, 0);
    post_b(36'h444444444);
    take_a(36'hF0F0F0F0F);
    chk("R8 mb2 reader empty", mb2_empty_a_o, 1);
    wait_b(4);
    chk("R8 mb2 writer empty", mb2_empty_b_o, 1);
    chk("R7 mb1 untouched", mb1_empty_b_o, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule